// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block watches the stream of results that an analog-to-digital converter writes into its result registers and flags values that cross programmed limits. It holds two independent monitors. Each one is pointed at a single result channel, carries its own 10-bit limit, and is set to react either to results above that limit or to results below it. A monitor is evaluated only when a fresh result lands in the channel it watches. When its condition holds and its interrupt is enabled, it emits a one-cycle interrupt pulse.

The converter side supplies a store strobe together with the channel index and the result value for each store. Software-side settings arrive as plain configuration inputs. Whether anyone has read the result registers plays no part. A monitor fires on every qualifying store, even if earlier results were never collected. Pointing both monitors at the same channel, one set to "above" and the other to "below", turns the pair into a window check: a result outside the window raises exactly one of the two interrupts.

Top module: `adc_thresh_mon`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both bits of `irq` are 0 after that edge.
- R2: A store (`store_vld`=1) whose `store_ch` equals the monitor's selected channel, with that monitor's enable and interrupt enable both 1 and its condition true, drives that monitor's `irq` bit to 1 in the clock cycle after the store and in no other cycle.
- R3: With the monitor's direction bit at 1 ("above"), the condition is result strictly greater than the limit. A result equal to the limit gives no interrupt, including the case where both are 1023.
- R4: With the direction bit at 0 ("below"), the condition is result strictly less than the limit. A result equal to the limit gives no interrupt, including the case where both are 0.
- R5: A store to any channel other than the selected one never fires that monitor.
- R6: A monitor whose enable bit is 0 never fires, whatever is stored.
- R7: A monitor whose interrupt-enable bit is 0 never fires, even when a matching store meets its condition.
- R8: Changing any configuration input, or changing `store_ch`/`store_data` while `store_vld` is 0, never produces an interrupt. New settings apply from the next store.
- R9: Two monitors on the same channel with opposite directions act as a window. A result above the upper limit fires only the "above" monitor, a result below the lower limit fires only the "below" monitor, and a result inside the window fires neither.
- R10: Stores on consecutive cycles are each judged on their own. Every interrupt is a single-cycle pulse tied to one store, and `irq` returns to 0 once stores stop.
- R11: The monitors are independent. Each bit of `irq` depends only on its own configuration slice (monitor 0 uses bit 0 and the low slice of every packed setting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| store_vld | input | 1 | A result is written this cycle |
| store_ch | input | 3 | Channel index of the written result |
| store_data | input | 10 | Written result value, unsigned |
| mon_en | input | 2 | Per-monitor enable |
| mon_sel | input | 6 | Per-monitor watched channel, 3 bits each, monitor 0 in bits 2:0 |
| mon_lim | input | 20 | Per-monitor limit, 10 bits each, monitor 0 in bits 9:0 |
| mon_above | input | 2 | Per-monitor direction: 1 = above limit, 0 = below limit |
| mon_irq_en | input | 2 | Per-monitor interrupt enable |
| irq | output | 2 | Per-monitor interrupt pulse, one cycle |

## Verification
Both monitors can fire in the same cycle, and a new store can arrive in the very cycle that the previous store's pulse appears. The bench provokes the first case by putting both monitors on one channel in the same direction, so that a single store fires both. It provokes the second with back-to-back stores that alternate between firing and non-firing values. A behavioural reference, which keeps a pending-pulse value per monitor in integers, is compared against `irq` on every clock. Directed checks with fixed expected values cover the limit-equality and window cases.

// File: rtl/adc_mon_pkg.sv
// Package: shared definitions for the ADC result threshold monitor.
// Assumes: results and limits are unsigned binary values.
package adc_mon_pkg;

    // Direction of the threshold test for one monitor.
    typedef enum logic {
        DIR_BELOW = 1'b0,
        DIR_ABOVE = 1'b1
    } mon_dir_e;

endpackage

// File: rtl/adc_mon_cmp.sv
// Module: unsigned magnitude comparator.
// Does: reports whether value is strictly above or strictly below limit.
// Assumes: both operands unsigned and the same width; equality sets neither output.
module adc_mon_cmp #(
    parameter int W = 10
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] limit,
    output logic         above,
    output logic         below
);

    // Strict comparisons in both directions.
    always_comb begin
        above = (value > limit);
        below = (value < limit);
    end

endmodule

// File: rtl/adc_mon_unit.sv
// Module: one threshold monitor.
// Does: on a store to the watched channel, tests the stored value against the
//       limit in the programmed direction and registers a one-cycle pulse.
// Assumes: configuration is sampled in the store cycle; no store, no pulse.
module adc_mon_unit
    import adc_mon_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_vld,
    input  logic [CH_W-1:0]  store_ch,
    input  logic [RES_W-1:0] store_data,
    input  logic             en,
    input  logic [CH_W-1:0]  sel,
    input  logic [RES_W-1:0] lim,
    input  logic             dir_above,
    input  logic             irq_en,
    output logic             irq
);

    logic     is_above;
    logic     is_below;
    logic     ch_hit;
    logic     cond;
    mon_dir_e dir;

    adc_mon_cmp #(.W(RES_W)) u_cmp (
        .value (store_data),
        .limit (lim),
        .above (is_above),
        .below (is_below)
    );

    // Qualify the store event and pick the directional result.
    always_comb begin
        dir    = mon_dir_e'(dir_above);
        ch_hit = store_vld && en && (store_ch == sel);
        cond   = (dir == DIR_ABOVE) ? is_above : is_below;
    end

    // Register the pulse one clock after the qualifying store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= ch_hit && cond && irq_en;
        end
    end

endmodule

// File: rtl/adc_thresh_mon.sv
// Module: ADC result threshold monitor, top level.
// Does: instantiates NUM_MON independent monitors sharing one result-store stream.
// Assumes: packed configuration vectors, monitor 0 in the lowest slice.
module adc_thresh_mon #(
    parameter int RES_W   = 10,
    parameter int CH_W    = 3,
    parameter int NUM_MON = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     store_vld,
    input  logic [CH_W-1:0]          store_ch,
    input  logic [RES_W-1:0]         store_data,
    input  logic [NUM_MON-1:0]       mon_en,
    input  logic [NUM_MON*CH_W-1:0]  mon_sel,
    input  logic [NUM_MON*RES_W-1:0] mon_lim,
    input  logic [NUM_MON-1:0]       mon_above,
    input  logic [NUM_MON-1:0]       mon_irq_en,
    output logic [NUM_MON-1:0]       irq
);

    // One monitor per slice of the packed configuration.
    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        adc_mon_unit #(
            .RES_W (RES_W),
            .CH_W  (CH_W)
        ) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .store_vld  (store_vld),
            .store_ch   (store_ch),
            .store_data (store_data),
            .en         (mon_en[g]),
            .sel        (mon_sel[g*CH_W +: CH_W]),
            .lim        (mon_lim[g*RES_W +: RES_W]),
            .dir_above  (mon_above[g]),
            .irq_en     (mon_irq_en[g]),
            .irq        (irq[g])
        );
    end

endmodule

// File: rtl/adc_thresh_mon_chk.sv
// Module: assertion checker for adc_thresh_mon, attached by bind.
// Does: relates each interrupt pulse to the store and settings one cycle earlier.
// Assumes: synchronous active-low reset on the checked block.
module adc_thresh_mon_chk #(
    parameter int RES_W   = 10,
    parameter int CH_W    = 3,
    parameter int NUM_MON = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     store_vld,
    input logic [CH_W-1:0]          store_ch,
    input logic [RES_W-1:0]         store_data,
    input logic [NUM_MON-1:0]       mon_en,
    input logic [NUM_MON*CH_W-1:0]  mon_sel,
    input logic [NUM_MON*RES_W-1:0] mon_lim,
    input logic [NUM_MON-1:0]       mon_above,
    input logic [NUM_MON-1:0]       mon_irq_en,
    input logic [NUM_MON-1:0]       irq
);

    // Reset leaves the outputs quiet.
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> irq == '0); // R1

    // Per-monitor properties.
    for (genvar g = 0; g < NUM_MON; g++) begin : g_chk
        AST_FIRE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (store_vld && mon_en[g] && mon_irq_en[g]
             && store_ch == mon_sel[g*CH_W +: CH_W]
             && (mon_above[g] ? (store_data > mon_lim[g*RES_W +: RES_W])
                              : (store_data < mon_lim[g*RES_W +: RES_W])))
            |=> irq[g]); // R2
        AST_ABOVE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && $past(mon_above[g]))
            |-> $past(store_data) > $past(mon_lim[g*RES_W +: RES_W])); // R3
        AST_BELOW_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !$past(mon_above[g]))
            |-> $past(store_data) < $past(mon_lim[g*RES_W +: RES_W])); // R4
        AST_CHANNEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(store_ch) == $past(mon_sel[g*CH_W +: CH_W])); // R5
        AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(mon_en[g])); // R6
        AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(mon_irq_en[g])); // R7
        AST_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(store_vld)); // R8
        AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !store_vld) |=> !irq[g]); // R10
    end

    // A window pair cannot report both sides for one result.
    AST_WINDOW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && irq[1] && $past(mon_sel[0 +: CH_W]) == $past(mon_sel[CH_W +: CH_W])
         && $past(mon_above[0]) != $past(mon_above[1])
         && $past(mon_lim[0 +: RES_W]) >= $past(mon_lim[RES_W +: RES_W])
         && $past(mon_lim[0 +: RES_W]) <= $past(mon_lim[RES_W +: RES_W]))
        |-> 1'b0); // R9

endmodule

bind adc_thresh_mon adc_thresh_mon_chk #(
    .RES_W   (RES_W),
    .CH_W    (CH_W),
    .NUM_MON (NUM_MON)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_vld  (store_vld),
    .store_ch   (store_ch),
    .store_data (store_data),
    .mon_en     (mon_en),
    .mon_sel    (mon_sel),
    .mon_lim    (mon_lim),
    .mon_above  (mon_above),
    .mon_irq_en (mon_irq_en),
    .irq        (irq)
);

// File: tb/adc_thresh_mon_tb.sv
`timescale 1ns/1ps
module adc_thresh_mon_tb;

    localparam int RES_W = 10;
    localparam int CH_W  = 3;
    localparam int NM    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             store_vld = 1'b0;
    logic [CH_W-1:0]  store_ch = '0;
    logic [RES_W-1:0] store_data = '0;
    logic [NM-1:0]       mon_en = '0;
    logic [NM*CH_W-1:0]  mon_sel = '0;
    logic [NM*RES_W-1:0] mon_lim = '0;
    logic [NM-1:0]       mon_above = '0;
    logic [NM-1:0]       mon_irq_en = '0;
    logic [NM-1:0]       irq;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    model_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic [NM-1:0] exp_irq = '0;

    always #2 clk = ~clk;

    adc_thresh_mon #(.RES_W(RES_W), .CH_W(CH_W), .NUM_MON(NM)) u_dut (
        .clk(clk), .rst_n(rst_n), .store_vld(store_vld), .store_ch(store_ch),
        .store_data(store_data), .mon_en(mon_en), .mon_sel(mon_sel),
        .mon_lim(mon_lim), .mon_above(mon_above), .mon_irq_en(mon_irq_en),
        .irq(irq)
    );

    // Behavioural reference: pending pulse per monitor, from integer compares.
    always @(posedge clk) begin
        for (int m = 0; m < NM; m++) begin
            int v, l, s, c;
            bit hit;
            v = int'(store_data);
            l = int'(mon_lim[m*RES_W +: RES_W]);
            s = int'(mon_sel[m*CH_W +: CH_W]);
            c = int'(store_ch);
            hit = 1'b0;
            if (rst_n && store_vld && mon_en[m] && mon_irq_en[m] && s == c) begin
                if (mon_above[m]) hit = (v > l);
                else              hit = (v < l);
            end
            exp_irq[m] <= hit;
        end
    end

    // Compare against the reference on every falling edge.
    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            n_chk++;
            if (irq !== exp_irq) begin
                n_bad++;
                $display("FAIL %s model: irq=%b expected=%b", cur_req, irq, exp_irq);
            end
        end
    end

    task automatic chk(input logic [NM-1:0] exp, input string req);
        n_chk++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s: irq=%b expected=%b", req, irq, exp);
        end
    endtask

    task automatic cfg(input int m, input bit en, input int sel, input int lim,
                       input bit above, input bit ie);
        mon_en[m]                  = en;
        mon_sel[m*CH_W +: CH_W]    = CH_W'(sel);
        mon_lim[m*RES_W +: RES_W]  = RES_W'(lim);
        mon_above[m]               = above;
        mon_irq_en[m]              = ie;
    endtask

    // Store one result; check irq one edge later (entered and left just after a negedge).
    task automatic put(input int ch, input int d, input logic [NM-1:0] exp, input string req);
        cur_req    = req;
        store_vld  = 1'b1;
        store_ch   = CH_W'(ch);
        store_data = RES_W'(d);
        @(negedge clk);
        chk(exp, req);
        store_vld = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk('0, req);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #40000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected<10000", cycles);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk('0, "R1");
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        chk('0, "R1");

        // R2/R3: above mode on channel 2
        cfg(0, 1, 2, 500, 1, 1);
        cfg(1, 0, 0, 0, 0, 0);
        put(2, 600, 2'b01, "R2");
        put(2, 500, 2'b00, "R3");
        put(2, 499, 2'b00, "R3");
        put(2, 501, 2'b01, "R3");
        cfg(0, 1, 2, 1023, 1, 1);
        put(2, 1023, 2'b00, "R3");

        // R5: other channels never fire
        cfg(0, 1, 2, 500, 1, 1);
        put(3, 900, 2'b00, "R5");
        put(0, 900, 2'b00, "R5");

        // R4: below mode
        cfg(0, 1, 2, 500, 0, 1);
        put(2, 400, 2'b01, "R4");
        put(2, 500, 2'b00, "R4");
        cfg(0, 1, 2, 0, 0, 1);
        put(2, 0, 2'b00, "R4");

        // R6/R7: enables
        cfg(0, 0, 2, 500, 0, 1);
        put(2, 100, 2'b00, "R6");
        cfg(0, 1, 2, 500, 0, 0);
        put(2, 100, 2'b00, "R7");

        // R8: settings and data move with no store
        cur_req = "R8";
        store_ch = 3'd2;
        store_data = 10'd100;
        cfg(0, 1, 2, 500, 0, 1);
        idle(2, "R8");
        cfg(0, 1, 2, 50, 1, 1);
        cfg(1, 1, 2, 900, 0, 1);
        idle(2, "R8");
        store_data = 10'd700;
        idle(2, "R8");
        put(2, 700, 2'b11, "R8");

        // R9: window on channel 5, 300..700
        cfg(0, 1, 5, 700, 1, 1);
        cfg(1, 1, 5, 300, 0, 1);
        put(5, 800, 2'b01, "R9");
        put(5, 200, 2'b10, "R9");
        put(5, 500, 2'b00, "R9");
        put(5, 700, 2'b00, "R9");
        put(5, 300, 2'b00, "R9");

        // R10: back-to-back stores
        put(5, 800, 2'b01, "R10");
        put(5, 800, 2'b01, "R10");
        put(5, 500, 2'b00, "R10");
        put(5, 100, 2'b10, "R10");
        put(5, 900, 2'b01, "R10");
        idle(3, "R10");

        // R11: independent channels, both firing together on one store
        cfg(0, 1, 1, 100, 1, 1);
        cfg(1, 1, 6, 100, 1, 1);
        put(6, 200, 2'b10, "R11");
        put(1, 200, 2'b01, "R11");
        cfg(1, 1, 1, 150, 1, 1);
        put(1, 200, 2'b11, "R11");
        put(1, 120, 2'b01, "R11");
        idle(2, "R11");

        // Pseudo-random sweep judged by the reference model.
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = (i * 7919 + 13) % 1024;
            if (i % 37 == 0) begin
                cfg(i % 2, 1, r % 8, (r * 3) % 1024, r[0], (r % 5) != 0);
            end
            store_vld  = (r % 3) != 0;
            store_ch   = CH_W'(r % 8);
            store_data = RES_W'((r * 11) % 1024);
            @(negedge clk);
        end
        store_vld = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule